// File: doc/BRIEF.md
# Burst Control Output Shaper

This block converts the frame timebase into the control pins that gate a radio's receive path, transmit path and synthesizer. It takes the quarterbit count of the current frame and finds the receive slot (slot 0), the transmit slot (slot 3) and the monitor slot (slot 6). A slot spans 625 counts, so slot k covers counts 625·k through 625·k+624. Each control channel has its own start and stop offset, measured from the first count of the slot. The channel is active while the offset is at or above its start and below its stop.

Each channel then passes through a shaping stage and a register. The shaping stage applies the channel's built-in default polarity. It then applies a polarity-invert bit and a mask bit. A mask bit of 0 clamps the pin to its inactive level, and that level is set by the polarity bit. Two further pins are always the complement of two transmit power-down channels. Reset and a low timing-enable input both drive every pin to its inactive level.

Top module: `bcs_out_shaper`

Channel map (the index is the bit position in `pol_i`, `mask_i` and `pins_o`, and field ch occupies bits [10·ch+9 : 10·ch] of the window vectors):

| Ch | Function | Slots |
|----|----------|-------|
| 0, 2, 3 | receive enable, receive power-down 1 and 2 | 0 and 6 |
| 1 | baseband enable | 0, 3 and 6 |
| 4 to 9 | transmit enable, PA key, ramp trigger, tx power-down 1, tx power-down 2, bias power-down | 3 |
| 10 | synthesizer power-down | 0, 3 and 6 |

## Requirements
- R1: After reset, and until the first clock edge that follows the release of reset, `pins_o` equals 13'b1_1001_0000_0000. Bits 8, 11 and 12 are high, and every other bit is low.
- R2: Channels 0, 2 and 3 become active only in slot 0 (counts 0..624) and slot 6 (counts 3750..4374). They are never active in slot 3.
- R3: Channels 4 to 9 become active only in slot 3 (counts 1875..2499).
- R4: Channels 1 and 10 become active in slots 0, 3 and 6.
- R5: Let the offset be the count minus the first count of the slot. A channel is active when the offset is at least its start and below its stop. When start ≥ stop, the channel is never active.
- R6: Every pin reflects the inputs sampled at the previous rising clock edge, so a change in the count shows on the pins one clock later.
- R7: The default active level is low for channel 8 and high for every other channel. A polarity bit of 1 inverts the channel.
- R8: A mask bit of 0 holds the channel at its inactive level. That level is 1 when the default-low flag XOR the polarity bit is 1, and 0 otherwise.
- R9: `pins_o[11]` is always the complement of `pins_o[7]`, and `pins_o[12]` is always the complement of `pins_o[9]`.
- R10: While `timing_en_i` is low, every channel is at its inactive level (default-low flag XOR polarity bit).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| qb_count_i | input | 13 | Quarterbit count within the frame |
| timing_en_i | input | 1 | Timing enable; when low, all pins are held inactive |
| pol_i | input | 11 | Per-channel polarity invert |
| mask_i | input | 11 | Per-channel mask; a 0 clamps the channel |
| win_start_i | input | 110 | Per-channel window start offset, 10 bits each |
| win_stop_i | input | 110 | Per-channel window stop offset, 10 bits each |
| pins_o | output | 13 | Control pins: 11 channels plus 2 complement pins |

## Verification
The hardest cases lie exactly at slot boundaries. Examples are count 624 against count 625, and count 1874 against count 1875. A full-length window (start 0, stop 625) must switch on and off exactly at those points. Per-channel slot membership must also be told apart at the same counts. The bench reaches these cases by driving the count input directly to each edge value. It applies several window settings, including full-slot, empty and reversed windows. It also steps through the polarity and mask combinations while a burst is active.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int NUM_CH   = 11;
  localparam int PIN_W    = NUM_CH + 2;
  localparam int CNT_W    = 13;
  localparam int OFF_W    = 10;
  localparam int NUM_SLOT = 3;
  localparam int CH_TXPD1 = 7;
  localparam int CH_BIAS  = 9;

  typedef logic [NUM_SLOT-1:0] slot_set_t;  // bit0 rx, bit1 tx, bit2 mon

  function automatic slot_set_t ch_slots(int ch);
    case (ch)
      0, 2, 3: return 3'b101;
      1, 10:   return 3'b111;
      default: return 3'b010;
    endcase
  endfunction

  function automatic logic ch_def_low(int ch);
    return ch == 8;
  endfunction
endpackage

// File: rtl/bcs_window.sv
module bcs_window
  import bcs_pkg::*;
#(
  parameter int        SLOT_LEN = 625,
  parameter int        RX_SLOT  = 0,
  parameter int        TX_SLOT  = 3,
  parameter int        MON_SLOT = 6,
  parameter slot_set_t SLOTS    = 3'b111
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] count_i,
  input  logic [OFF_W-1:0] start_i,
  input  logic [OFF_W-1:0] stop_i,
  output logic             hit_o
);
  logic [NUM_SLOT-1:0] slot_hit;
  logic [CNT_W-1:0]    start_x, stop_x;

  assign start_x = {{(CNT_W-OFF_W){1'b0}}, start_i};
  assign stop_x  = {{(CNT_W-OFF_W){1'b0}}, stop_i};

  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
    localparam int SNUM = (s == 0) ? RX_SLOT : (s == 1) ? TX_SLOT : MON_SLOT;
    localparam logic [CNT_W-1:0] BASE = CNT_W'(SLOT_LEN * SNUM);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOT_LEN * SNUM + SLOT_LEN);
    if (SLOTS[s]) begin : g_on
      logic             in_slot;
      logic [CNT_W-1:0] off;
      assign in_slot     = (count_i >= BASE) && (count_i < LAST);
      assign off         = count_i - BASE;
      assign slot_hit[s] = in_slot && (off >= start_x) && (off < stop_x);
    end else begin : g_off
      assign slot_hit[s] = 1'b0;
    end
  end

  assign hit_o = |slot_hit;

  // R5: empty or reversed window never fires
  a_r5_empty_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i >= stop_i) |-> !hit_o);
endmodule

// File: rtl/bcs_pin.sv
module bcs_pin #(
  parameter logic DEF_LOW = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic en_i,
  input  logic pol_i,
  input  logic mask_i,
  output logic pin_o
);
  logic inactive, pin_d, pin_q;

  assign inactive = DEF_LOW ^ pol_i;

  always_comb begin
    pin_d = inactive;
    if (mask_i && en_i && hit_i) pin_d = !inactive;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= DEF_LOW;
    else         pin_q <= pin_d;
  end

  assign pin_o = pin_q;

  a_r7_active_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i && en_i && hit_i) |=> (pin_o == !$past(DEF_LOW ^ pol_i)));
  a_r8_mask_clamp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_i |=> (pin_o == $past(DEF_LOW ^ pol_i)));
  a_r10_timing_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (pin_o == $past(DEF_LOW ^ pol_i)));
endmodule

// File: rtl/bcs_out_shaper.sv
module bcs_out_shaper
  import bcs_pkg::*;
#(
  parameter int SLOT_LEN = 625,
  parameter int RX_SLOT  = 0,
  parameter int TX_SLOT  = 3,
  parameter int MON_SLOT = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [CNT_W-1:0]        qb_count_i,
  input  logic                    timing_en_i,
  input  logic [NUM_CH-1:0]       pol_i,
  input  logic [NUM_CH-1:0]       mask_i,
  input  logic [NUM_CH*OFF_W-1:0] win_start_i,
  input  logic [NUM_CH*OFF_W-1:0] win_stop_i,
  output logic [PIN_W-1:0]        pins_o
);
  logic [NUM_CH-1:0] hit, ch_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    bcs_window #(
      .SLOT_LEN(SLOT_LEN), .RX_SLOT(RX_SLOT), .TX_SLOT(TX_SLOT),
      .MON_SLOT(MON_SLOT), .SLOTS(ch_slots(g))
    ) u_win (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .count_i (qb_count_i),
      .start_i (win_start_i[g*OFF_W +: OFF_W]),
      .stop_i  (win_stop_i[g*OFF_W +: OFF_W]),
      .hit_o   (hit[g])
    );
    bcs_pin #(.DEF_LOW(ch_def_low(g))) u_pin (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .hit_i  (hit[g]),
      .en_i   (timing_en_i),
      .pol_i  (pol_i[g]),
      .mask_i (mask_i[g]),
      .pin_o  (ch_q[g])
    );
  end

  // complement pins follow the registered power-down channels
  assign pins_o = {~ch_q[CH_BIAS], ~ch_q[CH_TXPD1], ch_q};

  a_r4_common_rx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timing_en_i && mask_i[1] && !pol_i[1] && hit[0] && win_start_i[OFF_W +: OFF_W] == win_start_i[0 +: OFF_W]
     && win_stop_i[OFF_W +: OFF_W] == win_stop_i[0 +: OFF_W]) |=> pins_o[1]);
endmodule

// File: tb/sim_bcs_out_shaper.sv
module sim_bcs_out_shaper;
  localparam int NCH = 11;
  localparam int OW  = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [12:0]       cnt = '0;
  logic              en = 1'b0;
  logic [NCH-1:0]    pol = '0;
  logic [NCH-1:0]    mask = '1;
  logic [NCH*OW-1:0] wstart, wstop;
  logic [12:0]       pins;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  bcs_out_shaper u0 (
    .clk_i(clk), .rst_ni(rst_n), .qb_count_i(cnt), .timing_en_i(en),
    .pol_i(pol), .mask_i(mask), .win_start_i(wstart), .win_stop_i(wstop),
    .pins_o(pins)
  );

  function automatic logic [12:0] model(int c, logic e, logic [NCH-1:0] p,
                                        logic [NCH-1:0] m);
    logic [12:0] o;
    for (int ch = 0; ch < NCH; ch++) begin
      logic [2:0] sl;
      logic hit = 1'b0, inact;
      int   st = int'(wstart[ch*OW +: OW]);
      int   sp = int'(wstop[ch*OW +: OW]);
      if (ch == 0 || ch == 2 || ch == 3) sl = 3'b101;      // R2
      else if (ch == 1 || ch == 10)      sl = 3'b111;      // R4
      else                               sl = 3'b010;      // R3
      for (int s = 0; s < 3; s++) begin
        int base = 625 * ((s == 0) ? 0 : (s == 1) ? 3 : 6);
        if (sl[s] && c >= base && c < base + 625 && c - base >= st && c - base < sp)
          hit = 1'b1;                                        // R5
      end
      inact = (ch == 8) ^ p[ch];                              // R7 R8
      o[ch] = (m[ch] && e && hit) ? !inact : inact;          // R10
    end
    o[11] = ~o[7];                                            // R9
    o[12] = ~o[9];
    return o;
  endfunction

  task automatic chk(string tag, logic [12:0] act, logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic apply(string tag, int c);
    @(negedge clk);
    cnt = 13'(c);
    @(negedge clk);
    chk(tag, pins, model(c, en, pol, mask));
  endtask

  task automatic set_default_windows();
    for (int ch = 0; ch < NCH; ch++) begin
      wstart[ch*OW +: OW] = OW'(5 + 3 * ch);
      wstop[ch*OW +: OW]  = OW'(40 + 7 * ch);
    end
  endtask

  task automatic t_reset();
    chk("R1 reset", pins, 13'b1_1001_0000_0000);
    rst_n = 1'b1;
    #1 chk("R1 post-release", pins, 13'b1_1001_0000_0000);
    en = 1'b1;
  endtask

  task automatic t_slots();
    int offs[4] = '{20, 45, 60, 100};
    for (int k = 0; k < 8; k++)
      for (int i = 0; i < 4; i++)
        apply($sformatf("R2 R3 R4 slot%0d off%0d", k, offs[i]), 625 * k + offs[i]);
  endtask

  task automatic t_edges();
    int st = 5 + 3 * 4, sp = 40 + 7 * 4;
    apply("R5 tx before start", 1875 + st - 1);
    apply("R5 tx at start", 1875 + st);
    apply("R5 tx last", 1875 + sp - 1);
    apply("R5 tx at stop", 1875 + sp);
    wstart[1*OW +: OW] = '0;  wstop[1*OW +: OW] = 10'd625;
    wstart[0*OW +: OW] = '0;  wstop[0*OW +: OW] = 10'd625;
    apply("R2 R4 full 624", 624);
    apply("R2 R4 full 625", 625);
    apply("R4 full 1874", 1874);
    apply("R4 full 1875", 1875);
    apply("R2 full 4374", 4374);
    apply("R2 full 4375", 4375);
    wstart[0*OW +: OW] = 10'd50; wstop[0*OW +: OW] = 10'd50;
    wstart[2*OW +: OW] = 10'd60; wstop[2*OW +: OW] = 10'd20;
    for (int c = 0; c < 120; c += 10) apply("R5 empty/reversed", c);
    set_default_windows();
  endtask

  task automatic t_latency();
    logic [12:0] idle;
    apply("R6 idle", 4999);
    idle = pins;
    @(negedge clk);
    cnt = 13'(1875 + 20);
    #1 chk("R6 not yet", pins, idle);
    @(posedge clk); #1;
    chk("R6 after edge", pins, model(1875 + 20, en, pol, mask));
  endtask

  task automatic t_polarity();
    pol = 11'b101_0101_0101;
    apply("R7 pol burst tx", 1875 + 30);
    apply("R7 pol idle", 4999);
    pol = '1;
    apply("R7 pol all rx", 30);
    pol = '0;
    apply("R7 ch8 default low", 1875 + 62);
  endtask

  task automatic t_mask();
    mask = 11'b010_1010_1010;
    apply("R8 mask pol0", 1875 + 40);
    pol = 11'b110_0110_0110;
    apply("R8 mask pol mix", 1875 + 40);
    apply("R8 mask rx", 3750 + 30);
    mask = '1; pol = '0;
    apply("R9 complement burst", 1875 + 40);
  endtask

  task automatic t_disable();
    en = 1'b0;
    apply("R10 disabled tx", 1875 + 40);
    pol = 11'b011_0011_0011;
    apply("R10 disabled pol", 30);
    en = 1'b1; pol = '0;
    apply("R10 re-enabled", 30);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    set_default_windows();
    #25;
    t_reset();
    t_slots();
    t_edges();
    t_latency();
    t_polarity();
    t_mask();
    t_disable();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule